// File: doc/BRIEF.md
# Smart Card Character Convention Codec

This block turns an 8-bit byte into the ten-bit line frame of an asynchronous smart card character, and turns such a frame back into a byte. A frame holds a start bit, eight data bits and a parity bit. Three independent control inputs set how the byte is laid out on the line. The first picks which data bit is sent first. The second inverts the eight data levels. The third picks even or odd parity. The line uses two levels: A is low and Z is high. A logical 1 is sent as Z unless the data are inverted.

The block moves one bit position per `bit_en` strobe, so bit timing stays with the surrounding logic. The transmit half latches a byte and its controls when `tx_start` is accepted. It then steps `tx_line` through the frame and pulses `tx_done` after the parity bit. The receive half waits for a low level on `rx_line` at a strobe. It then collects the data and parity bits at the next nine strobes and returns the byte with a parity-error flag. Both halves read the controls once, when their frame begins.

Top module: `sc_conv_codec`

## Requirements
- R1: While idle, `tx_line` is Z (1). A transmitted frame is the start bit A (0), then eight data bits, then the parity bit. Each position takes the line from one `bit_en` strobe until the next. The start bit appears on the cycle after `tx_start` is accepted.
- R2: With `cfg_msb_first`=0 the data bits are sent and received bit 0 first. With `cfg_msb_first`=1 they are sent and received bit 7 first.
- R3: With `cfg_invert`=1 the level of each of the eight data bits is complemented on the line. The start bit and the parity bit are never complemented.
- R4: The parity bit is the XOR of the eight logical data bits (before inversion), XORed with `cfg_odd_parity`. Even parity is 0 and odd parity is 1.
- R5: With all controls at 0, byte 0x3B is sent as the line levels 0, 1,1,0,1,1,1,0,0, 1. A receiver given those levels returns 0x3B with no parity error.
- R6: With all controls at 1, byte 0x3F is sent as the line levels 0, 1,1,0,0,0,0,0,0, 1. A receiver given those levels returns 0x3F with no parity error.
- R7: The receiver reads a frame with the same layout rules as the transmitter. At the strobe that samples the parity bit it updates `rx_data` and pulses `rx_done` for one cycle. `rx_data` keeps its value until the next frame completes.
- R8: `rx_parity_err` is 1 when the received parity level differs from the level that R4 computes from the decoded byte. Otherwise it is 0.
- R9: Control inputs are sampled when a frame starts. A change during a frame takes effect only from the next frame, on both the transmit and the receive side.
- R10: `tx_done` pulses for one cycle at the strobe after the parity bit, and `tx_line` returns to Z at that strobe. `tx_busy` is 1 from the accepted start until that strobe. `tx_start` is ignored while `tx_busy` is 1.
- R11: After reset `tx_line`=1 and `tx_busy`, `tx_done` and `rx_done` are 0.
- R12: While the receiver is idle, a strobe that samples `rx_line` at Z does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe that advances one bit position |
| cfg_msb_first | input | 1 | 1: bit 7 first, 0: bit 0 first |
| cfg_invert | input | 1 | 1: complement the data-bit levels |
| cfg_odd_parity | input | 1 | 1: odd parity, 0: even parity |
| tx_start | input | 1 | Request to send `tx_data` (accepted when not busy) |
| tx_data | input | 8 | Byte to transmit |
| tx_line | output | 1 | Transmit line level (1 = Z, 0 = A) |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_done | output | 1 | One-cycle pulse after the parity bit |
| rx_line | input | 1 | Receive line level (1 = Z, 0 = A) |
| rx_data | output | 8 | Last decoded byte |
| rx_parity_err | output | 1 | Parity mismatch on the last decoded byte |
| rx_done | output | 1 | One-cycle pulse when a frame is decoded |

## Verification
The in-module assertions check on every cycle that:
- the start bit is low and the idle line is high;
- the position counters stay in range;
- the done pulses last a single cycle and come only at the strobe after the last position;
- the idle receiver does not react to a high line;
- the received byte changes only with a done pulse.

The data layout itself is shown only by the bench scenarios. These cover bit order, inversion, parity sense, the two start-character patterns, injected parity faults, controls changed during a frame, and random bytes sent in loopback.

// File: rtl/sc_conv_pkg.sv
package sc_conv_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned POS_W   = $clog2(FRAME_W);

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam pos_t LAST_POS = pos_t'(FRAME_W - 1);

    localparam logic LVL_A = 1'b0;
    localparam logic LVL_Z = 1'b1;

    typedef struct packed {
        logic msb_first;
        logic invert;
        logic odd_par;
    } conv_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // Lane i of the result is the i-th data bit on the line.
    // The mapping is its own inverse, so the receiver uses it as well.
    function automatic data_t lane_order(data_t d, logic msb_first);
        data_t r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = msb_first ? d[DATA_W-1-i] : d[i];
        end
        return r;
    endfunction

    function automatic data_t lane_levels(data_t lanes, logic invert);
        return lanes ^ {DATA_W{invert}};
    endfunction

    function automatic logic parity_level(data_t logical, logic odd_par);
        return (^logical) ^ odd_par;
    endfunction

endpackage

// File: rtl/sc_conv_tx.sv
module sc_conv_tx
    import sc_conv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  conv_t conv,
    input  logic  start,
    input  data_t data,
    output logic  line,
    output logic  busy,
    output logic  done
);

    phase_t               phase_q;
    pos_t                 pos_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [FRAME_W-1:0]   frame_new;
    logic                 line_q;
    logic                 done_q;

    // Start level in position 0, parity level in the last position.
    always_comb begin
        frame_new = {parity_level(data, conv.odd_par),
                     lane_levels(lane_order(data, conv.msb_first), conv.invert),
                     LVL_A};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pos_q   <= '0;
            frame_q <= '1;
            line_q  <= LVL_Z;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        frame_q <= frame_new;
                        line_q  <= LVL_A;
                        pos_q   <= '0;
                        phase_q <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (bit_en) begin
                        if (pos_q == LAST_POS) begin
                            line_q  <= LVL_Z;
                            done_q  <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else begin
                            line_q  <= frame_q[1];
                            frame_q <= {LVL_Z, frame_q[FRAME_W-1:1]};
                            pos_q   <= pos_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign line = line_q;
    assign busy = (phase_q == PH_RUN);
    assign done = done_q;

    assert_start_low_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && pos_q == '0) |-> (line_q == LVL_A));

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (line_q == LVL_Z));

    assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_done_after_parity_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(pos_q) == LAST_POS && $past(bit_en) && $past(busy)));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !bit_en) |=> (busy && $stable(pos_q)));

endmodule

// File: rtl/sc_conv_rx.sv
module sc_conv_rx
    import sc_conv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    input  conv_t conv,
    input  logic  line,
    output data_t data,
    output logic  par_err,
    output logic  done
);

    phase_t phase_q;
    pos_t   pos_q;
    conv_t  conv_q;
    data_t  lanes_q;
    data_t  data_q;
    logic   err_q;
    logic   done_q;
    data_t  decoded;

    always_comb begin
        decoded = lane_order(lane_levels(lanes_q, conv_q.invert), conv_q.msb_first);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pos_q   <= '0;
            conv_q  <= '0;
            lanes_q <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (bit_en && line == LVL_A) begin
                        conv_q  <= conv;
                        pos_q   <= pos_t'(1);
                        phase_q <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (bit_en) begin
                        if (pos_q == LAST_POS) begin
                            data_q  <= decoded;
                            err_q   <= (line != parity_level(decoded, conv_q.odd_par));
                            done_q  <= 1'b1;
                            pos_q   <= '0;
                            phase_q <= PH_IDLE;
                        end else begin
                            lanes_q <= {line, lanes_q[DATA_W-1:1]};
                            pos_q   <= pos_q + 1'b1;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign data    = data_q;
    assign par_err = err_q;
    assign done    = done_q;

    assert_rx_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN) |-> (pos_q != '0 && pos_q <= LAST_POS));

    assert_rx_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (data_q != $past(data_q) || err_q != $past(err_q)) |-> done_q);

    assert_rx_idle_high_R12: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && bit_en && line == LVL_Z) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/sc_conv_codec.sv
module sc_conv_codec
    import sc_conv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       cfg_msb_first,
    input  logic       cfg_invert,
    input  logic       cfg_odd_parity,
    input  logic       tx_start,
    input  logic [7:0] tx_data,
    output logic       tx_line,
    output logic       tx_busy,
    output logic       tx_done,
    input  logic       rx_line,
    output logic [7:0] rx_data,
    output logic       rx_parity_err,
    output logic       rx_done
);

    conv_t conv;

    always_comb begin
        conv.msb_first = cfg_msb_first;
        conv.invert    = cfg_invert;
        conv.odd_par   = cfg_odd_parity;
    end

    sc_conv_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .conv   (conv),
        .start  (tx_start),
        .data   (tx_data),
        .line   (tx_line),
        .busy   (tx_busy),
        .done   (tx_done)
    );

    sc_conv_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .conv    (conv),
        .line    (rx_line),
        .data    (rx_data),
        .par_err (rx_parity_err),
        .done    (rx_done)
    );

    assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !tx_busy);

endmodule

// File: tb/test_sc_conv_codec.sv
module test_sc_conv_codec;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_odd_parity = 1'b0;
    logic       tx_start = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_line;
    logic       tx_busy;
    logic       tx_done;
    logic       rx_line;
    logic [7:0] rx_data;
    logic       rx_parity_err;
    logic       rx_done;

    logic       loop_en = 1'b0;
    logic       rx_drive = 1'b1;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    assign rx_line = loop_en ? tx_line : rx_drive;

    always #2 clk = ~clk;

    sc_conv_codec i_sc_conv_codec (
        .clk            (clk),
        .rst            (rst),
        .bit_en         (bit_en),
        .cfg_msb_first  (cfg_msb_first),
        .cfg_invert     (cfg_invert),
        .cfg_odd_parity (cfg_odd_parity),
        .tx_start       (tx_start),
        .tx_data        (tx_data),
        .tx_line        (tx_line),
        .tx_busy        (tx_busy),
        .tx_done        (tx_done),
        .rx_line        (rx_line),
        .rx_data        (rx_data),
        .rx_parity_err  (rx_parity_err),
        .rx_done        (rx_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Line levels of a frame, index 0 = start bit, index 9 = parity bit.
    function automatic logic [9:0] model_frame(logic [7:0] d, logic msb, logic inv, logic odd);
        logic [9:0] f;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            f[1+i] = (msb ? d[7-i] : d[i]) ^ inv;
        end
        f[9] = (^d) ^ odd;
        return f;
    endfunction

    task automatic strobe();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    task automatic set_cfg(input logic m, input logic i, input logic o);
        cfg_msb_first  = m;
        cfg_invert     = i;
        cfg_odd_parity = o;
    endtask

    // Sends one frame and checks every line position against exp_f.
    // flip_mid changes the controls and pulses tx_start in the middle of the frame.
    task automatic send(input logic [7:0] d, input logic [9:0] exp_f,
                        input bit loop, input bit flip_mid, input string tag);
        loop_en = loop;
        @(negedge clk) begin tx_data = d; tx_start = 1'b1; end
        @(negedge clk) tx_start = 1'b0;
        check(tx_line == 1'b0 && tx_busy, {tag, " R1 start"}, {tx_busy, tx_line}, 2);
        for (int k = 1; k < 10; k++) begin
            strobe();
            check(tx_line == exp_f[k], {tag, (k == 9) ? " R4 parity" : " R2 R3 data"},
                  tx_line, exp_f[k]);
            if (flip_mid && k == 2) begin
                set_cfg(~cfg_msb_first, ~cfg_invert, ~cfg_odd_parity);
                tx_data  = ~d;
                tx_start = 1'b1;
                @(negedge clk) tx_start = 1'b0;
                check(tx_busy == 1'b1, {tag, " R10 busy"}, tx_busy, 1);
            end
        end
        strobe();
        check(tx_line == 1'b1 && tx_done && !tx_busy, {tag, " R10 end"},
              {tx_line, tx_done, tx_busy}, 3'b110);
        if (loop) begin
            check(rx_done == 1'b1, {tag, " R7 rx_done"}, rx_done, 1);
            check(rx_data == d && !rx_parity_err, {tag, " R7 rx_data"},
                  {rx_parity_err, rx_data}, {1'b0, d});
        end
        @(negedge clk);
        check(!tx_done && tx_line, {tag, " R10 pulse"}, {tx_done, tx_line}, 1);
        loop_en = 1'b0;
    endtask

    task automatic recv(input logic [9:0] lv, input logic [7:0] exp_d,
                        input logic exp_err, input string tag);
        loop_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            rx_drive = lv[k];
            strobe();
        end
        rx_drive = 1'b1;
        check(rx_done == 1'b1, {tag, " rx_done"}, rx_done, 1);
        check(rx_data == exp_d && rx_parity_err == exp_err, tag,
              {rx_parity_err, rx_data}, {exp_err, exp_d});
        @(negedge clk);
        check(rx_done == 1'b0 && rx_data == exp_d, {tag, " R7 hold"}, {rx_done, rx_data}, exp_d);
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] d;
        logic m, iv, o;

        seed = 32'h5eed_0c0d;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(tx_line == 1'b1 && !tx_busy && !tx_done && !rx_done, "R11 reset",
              {tx_line, tx_busy, tx_done, rx_done}, 4'b1000);

        // R5 direct convention start character
        set_cfg(1'b0, 1'b0, 1'b0);
        send(8'h3B, 10'b1001110110, 1'b1, 1'b0, "R5 tx");
        recv(10'b1001110110, 8'h3B, 1'b0, "R5 rx");

        // R6 inverse convention start character
        set_cfg(1'b1, 1'b1, 1'b1);
        send(8'h3F, 10'b1000000110, 1'b1, 1'b0, "R6 tx");
        recv(10'b1000000110, 8'h3F, 1'b0, "R6 rx");

        // R8 parity faults under both conventions
        set_cfg(1'b0, 1'b0, 1'b0);
        recv(10'b0001110110, 8'h3B, 1'b1, "R8 direct");
        set_cfg(1'b1, 1'b1, 1'b1);
        recv(10'b0000000110, 8'h3F, 1'b1, "R8 inverse");

        // R2 R3 R4 single controls, each alone
        set_cfg(1'b1, 1'b0, 1'b0);
        send(8'h01, model_frame(8'h01, 1'b1, 1'b0, 1'b0), 1'b1, 1'b0, "R2 msb");
        set_cfg(1'b0, 1'b1, 1'b0);
        send(8'h0F, model_frame(8'h0F, 1'b0, 1'b1, 1'b0), 1'b1, 1'b0, "R3 inv");
        set_cfg(1'b0, 1'b0, 1'b1);
        send(8'h00, model_frame(8'h00, 1'b0, 1'b0, 1'b1), 1'b1, 1'b0, "R4 odd");

        // R12 idle strobes at Z are ignored, then a frame still decodes
        set_cfg(1'b0, 1'b0, 1'b0);
        rx_drive = 1'b1;
        for (int k = 0; k < 12; k++) begin
            strobe();
            check(rx_done == 1'b0, "R12 idle", rx_done, 0);
        end
        recv(model_frame(8'hA5, 1'b0, 1'b0, 1'b0), 8'hA5, 1'b0, "R12 rx");

        // R9 controls changed mid-frame, plus R10 start ignored while busy
        set_cfg(1'b1, 1'b0, 1'b1);
        send(8'h6C, model_frame(8'h6C, 1'b1, 1'b0, 1'b1), 1'b1, 1'b1, "R9 flip");
        set_cfg(1'b0, 1'b1, 1'b0);
        send(8'h93, model_frame(8'h93, 1'b0, 1'b1, 1'b0), 1'b1, 1'b1, "R9 flip2");

        // Random bytes and controls in loopback (R7)
        for (int n = 0; n < 40; n++) begin
            d  = 8'($urandom);
            m  = 1'($urandom);
            iv = 1'($urandom);
            o  = 1'($urandom);
            set_cfg(m, iv, o);
            send(d, model_frame(d, m, iv, o), 1'b1, 1'b0, "R7 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule